// File: doc/BRIEF.md
# Leaky Bucket Activity Alarm

This block decides, for each of two monitored clocks, whether that clock is failing. It counts how often the clock goes inactive. Time is cut into monitoring intervals. An external strobe marks each interval with a single system-clock pulse. A missing-edge detector runs on the faster system clock and watches each monitored clock. It flags an interval when the gap between two synchronized rising edges of the monitored clock is longer than a per-type limit, counted in system-clock cycles. The limit depends on whether the input is of the normal type or the high-rate type.

Each input has its own saturating accumulator, called the bucket. At each strobe, a flagged interval adds one unit to the bucket. Clean intervals drain the bucket by one unit at the end of every leak period. The leak period is 1, 2, 4 or 8 intervals, chosen by a 2-bit decay exponent. A flagged interval blocks the leak and restarts the leak period. Each input also has a two-state alarm machine.

- ST_QUIET is left for ST_ALARMED (transition DECLARE) when the bucket reaches the declare threshold.
- ST_ALARMED is left for ST_QUIET (transition RELEASE) when the bucket falls to the clear threshold.
- Otherwise the machine stays in its state (HOLD).

While its alarm is active, an input is reported invalid. The bucket size, the two thresholds and the decay exponent form one configuration set, which both inputs share. Legal settings satisfy size ≥ declare > clear.

Top module: `lb_activity_alarm`

## Requirements
- R1: An interval is flagged when the monitored clock has a gap longer than STD_LIMIT system cycles between synchronized rising edges. A flagged interval raises the bucket by exactly one at its strobe, however long or frequent its gaps were. The bucket changes only on a strobe.
- R2: When fast_sel for an input is 1, the gap limit for that input is FAST_LIMIT instead of STD_LIMIT. A gap between the two limits is then not flagged.
- R3: When no flagged interval occurs, the bucket falls by one once every 2^cfg_decay strobes. For example, with cfg_decay = 1 it falls on every second clean strobe.
- R4: A flagged interval never drains the bucket, and it restarts the leak period from zero.
- R5: When the bucket reaches cfg_declare, act_alarm for that input goes to 1 and in_valid goes to 0. Both change in the same cycle as the bucket update.
- R6: An active alarm stays set until the bucket falls to cfg_clear or below. The alarm then goes to 0 and in_valid goes back to 1.
- R7: The bucket never exceeds cfg_size. Extra flagged intervals at full size add nothing.
- R8: The bucket never drops below zero. Clean intervals at empty have no effect.
- R9: Both inputs use the same configuration, but each input keeps its own bucket, leak period and alarm.
- R10: During and after reset, act_alarm is 0 and in_valid is 1 for both inputs. The buckets and leak periods start at zero.
- R11: When a monitored clock is stopped across a strobe, the interval that follows the strobe is also flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the monitored clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| interval_tick | input | 1 | One-cycle pulse that ends each monitoring interval |
| mon_clk | input | N_IN | Monitored clocks, sampled as asynchronous data |
| fast_sel | input | N_IN | 1 selects the longer high-rate gap limit for that input |
| cfg_size | input | ACC_W | Bucket capacity |
| cfg_declare | input | ACC_W | Level at which the alarm is declared |
| cfg_clear | input | ACC_W | Level at which an active alarm is released |
| cfg_decay | input | 2 | Leak period exponent: one unit leaks per 2^cfg_decay clean intervals |
| act_alarm | output | N_IN | Activity alarm per input |
| in_valid | output | N_IN | 1 while the input has no active alarm |

## Verification
The bench builds the block with its default parameters: STD_LIMIT = 10, FAST_LIMIT = 18, two inputs and a 6-bit bucket. Intervals are shortened to 60 system cycles. The monitored clocks have a period of 4 cycles. Their stalls widen an edge gap to 14 or 30 cycles, or stop the clock outright. A 14-cycle gap lies between the two limits, so the same stimulus is flagged on a normal-type input and passes on a high-rate input. Small thresholds and sizes let a few dozen intervals reach saturation, the hysteresis release, the restart of the leak period, and all four decay exponents.

// File: rtl/lb_alarm_pkg.sv
package lb_alarm_pkg;

    typedef enum logic [0:0] {
        ST_QUIET   = 1'b0,
        ST_ALARMED = 1'b1
    } bkt_state_e;

    // Leak period ends when the interval counter hits 2^decay - 1.
    function automatic logic leak_period_done(input logic [2:0] lk, input logic [1:0] decay);
        logic done;
        unique case (decay)
            2'd0:    done = 1'b1;
            2'd1:    done = lk[0];
            2'd2:    done = (lk[1:0] == 2'b11);
            default: done = (lk == 3'b111);
        endcase
        return done;
    endfunction

endpackage

// File: rtl/lb_gap_detect.sv
module lb_gap_detect #(
    parameter int STD_LIMIT  = 10,
    parameter int FAST_LIMIT = 18,
    parameter int CNT_W      = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_clk,
    input  logic fast_sel,
    input  logic interval_tick,
    output logic gap_flag
);

    localparam logic [CNT_W-1:0] STD_L  = CNT_W'(STD_LIMIT);
    localparam logic [CNT_W-1:0] FAST_L = CNT_W'(FAST_LIMIT);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [2:0]       sync_q;
    logic             mon_rise;
    logic [CNT_W-1:0] since_edge;
    logic [CNT_W-1:0] limit;
    logic             gap_now;
    logic             gap_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], mon_clk};
    end

    assign mon_rise = sync_q[1] & ~sync_q[2];
    assign limit    = fast_sel ? FAST_L : STD_L;

    always_ff @(posedge clk) begin
        if (!rst_n)                  since_edge <= '0;
        else if (mon_rise)           since_edge <= '0;
        else if (since_edge != CNT_MAX) since_edge <= since_edge + 1'b1;
    end

    assign gap_now = (since_edge > limit);

    always_ff @(posedge clk) begin
        if (!rst_n)             gap_seen <= 1'b0;
        else if (interval_tick) gap_seen <= 1'b0;
        else if (gap_now)       gap_seen <= 1'b1;
    end

    assign gap_flag = gap_seen | gap_now;

    // R1
    gap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_seen && !interval_tick) |=> gap_seen);

    // R1
    edge_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mon_rise |=> !gap_now);

endmodule

// File: rtl/lb_bucket.sv
module lb_bucket
    import lb_alarm_pkg::*;
#(
    parameter int ACC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             interval_tick,
    input  logic             fill,
    input  logic [ACC_W-1:0] cfg_size,
    input  logic [ACC_W-1:0] cfg_declare,
    input  logic [ACC_W-1:0] cfg_clear,
    input  logic [1:0]       cfg_decay,
    output logic             alarm
);

    bkt_state_e       state_q, state_d;
    logic [ACC_W-1:0] acc_q, acc_d;
    logic [2:0]       lk_q, lk_d;
    logic             period_end;

    assign period_end = leak_period_done(lk_q, cfg_decay);

    // Bucket level and leak-period counter
    always_comb begin
        acc_d = acc_q;
        lk_d  = lk_q;
        if (interval_tick) begin
            if (fill) begin
                lk_d = '0;
                if (acc_q < cfg_size) acc_d = acc_q + 1'b1;
            end else if (period_end) begin
                lk_d = '0;
                if (acc_q != '0) acc_d = acc_q - 1'b1;
            end else begin
                lk_d = lk_q + 1'b1;
            end
        end
    end

    // Alarm state transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:   if (acc_d >= cfg_declare) state_d = ST_ALARMED;
            ST_ALARMED: if (acc_d <= cfg_clear)   state_d = ST_QUIET;
            default:    state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
            acc_q   <= '0;
            lk_q    <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
            lk_q    <= lk_d;
        end
    end

    always_comb begin
        alarm = (state_q == ST_ALARMED);
    end

    // R7
    acc_in_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= cfg_size);

    // R1
    acc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !interval_tick |=> $stable(acc_q));

    // R1
    acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        interval_tick |=> (acc_q == $past(acc_q)) || (acc_q == $past(acc_q) + 1'b1)
                          || ($past(acc_q) == acc_q + 1'b1));

    // R4
    fill_no_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (interval_tick && fill) |=> acc_q >= $past(acc_q));

    // R5
    alarm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> acc_q >= cfg_declare);

    // R6
    alarm_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm) |-> acc_q <= cfg_clear);

endmodule

// File: rtl/lb_activity_alarm.sv
module lb_activity_alarm #(
    parameter int N_IN       = 2,
    parameter int ACC_W      = 6,
    parameter int STD_LIMIT  = 10,
    parameter int FAST_LIMIT = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              interval_tick,
    input  logic [N_IN-1:0]   mon_clk,
    input  logic [N_IN-1:0]   fast_sel,
    input  logic [ACC_W-1:0]  cfg_size,
    input  logic [ACC_W-1:0]  cfg_declare,
    input  logic [ACC_W-1:0]  cfg_clear,
    input  logic [1:0]        cfg_decay,
    output logic [N_IN-1:0]   act_alarm,
    output logic [N_IN-1:0]   in_valid
);

    localparam int MAX_LIMIT = (FAST_LIMIT > STD_LIMIT) ? FAST_LIMIT : STD_LIMIT;
    localparam int CNT_W     = $clog2(MAX_LIMIT + 2) + 1;

    logic [N_IN-1:0] gap_flag;

    for (genvar g = 0; g < N_IN; g++) begin : g_input
        lb_gap_detect #(
            .STD_LIMIT (STD_LIMIT),
            .FAST_LIMIT(FAST_LIMIT),
            .CNT_W     (CNT_W)
        ) i_detect (
            .clk          (clk),
            .rst_n        (rst_n),
            .mon_clk      (mon_clk[g]),
            .fast_sel     (fast_sel[g]),
            .interval_tick(interval_tick),
            .gap_flag     (gap_flag[g])
        );

        lb_bucket #(
            .ACC_W(ACC_W)
        ) i_bucket (
            .clk          (clk),
            .rst_n        (rst_n),
            .interval_tick(interval_tick),
            .fill         (gap_flag[g]),
            .cfg_size     (cfg_size),
            .cfg_declare  (cfg_declare),
            .cfg_clear    (cfg_clear),
            .cfg_decay    (cfg_decay),
            .alarm        (act_alarm[g])
        );
    end

    assign in_valid = ~act_alarm;

    // R10
    reset_valid_chk: assert property (@(posedge clk)
        !rst_n |=> (act_alarm == '0));

endmodule

// File: tb/test_lb_activity_alarm.sv
module test_lb_activity_alarm;

    localparam int ACC_W = 6;
    localparam int IVL   = 60;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             interval_tick = 1'b0;
    logic [1:0]       mon_clk = 2'b00;
    logic [1:0]       fast_sel = 2'b00;
    logic [ACC_W-1:0] cfg_size = 6'd10;
    logic [ACC_W-1:0] cfg_declare = 6'd8;
    logic [ACC_W-1:0] cfg_clear = 6'd1;
    logic [1:0]       cfg_decay = 2'd0;
    logic [1:0]       act_alarm;
    logic [1:0]       in_valid;

    always #5 clk = ~clk;

    lb_activity_alarm i_lb_activity_alarm (
        .clk(clk), .rst_n(rst_n), .interval_tick(interval_tick),
        .mon_clk(mon_clk), .fast_sel(fast_sel),
        .cfg_size(cfg_size), .cfg_declare(cfg_declare), .cfg_clear(cfg_clear),
        .cfg_decay(cfg_decay), .act_alarm(act_alarm), .in_valid(in_valid)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_req = "R10";

    // reference model
    int m_acc [2];
    int m_lk  [2];
    bit m_alm [2];
    bit prev_dead [2];
    // clock generators
    int ph [2];
    int stall [2];
    bit pend [2];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_outputs();
        logic [1:0] ea;
        ea = {m_alm[1], m_alm[0]};
        check(act_alarm == ea && in_valid == ~ea, cur_req,
              {act_alarm, in_valid}, {ea, ~ea});
    endtask

    task automatic model_tick(input bit f0, input bit f1);
        for (int i = 0; i < 2; i++) begin
            bit f;
            f = (i == 0) ? f0 : f1;
            if (f) begin
                m_lk[i] = 0;
                if (m_acc[i] < cfg_size) m_acc[i]++;
            end else if (m_lk[i] + 1 >= (1 << cfg_decay)) begin
                m_lk[i] = 0;
                if (m_acc[i] > 0) m_acc[i]--;
            end else begin
                m_lk[i]++;
            end
            if (!m_alm[i] && m_acc[i] >= cfg_declare) m_alm[i] = 1;
            else if (m_alm[i] && m_acc[i] <= cfg_clear) m_alm[i] = 0;
        end
    endtask

    // kinds: 0 clean, 1 gap of 14 cycles, 2 gap of 30 cycles, 3 stopped clock
    task automatic run_interval(input int k0, input int k1);
        int kind [2];
        bit fl [2];
        kind[0] = k0; kind[1] = k1;
        for (int i = 0; i < 2; i++) begin
            fl[i] = prev_dead[i] || (kind[i] == 2) || (kind[i] == 3)
                    || (kind[i] == 1 && !fast_sel[i]);
            prev_dead[i] = (kind[i] == 3);
        end
        for (int c = 0; c < IVL; c++) begin
            @(negedge clk);
            compare_outputs();
            for (int i = 0; i < 2; i++) begin
                if (c == 20 && (kind[i] == 1 || kind[i] == 2)) pend[i] = 1;
                if (kind[i] == 3) begin
                    mon_clk[i] = 1'b0;
                end else begin
                    if (pend[i] && ph[i] == 2) begin
                        stall[i] = (kind[i] == 1) ? 10 : 26;
                        pend[i]  = 0;
                    end
                    if (stall[i] > 0) begin
                        mon_clk[i] = 1'b0;
                        stall[i]--;
                    end else begin
                        mon_clk[i] = (ph[i] < 2);
                        ph[i] = (ph[i] + 1) % 4;
                    end
                end
            end
            interval_tick = (c == IVL - 1);
            if (c == IVL - 1) model_tick(fl[0], fl[1]);
        end
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input int sz, input int dcl, input int clr, input int dec, input logic [1:0] fs);
        @(negedge clk);
        rst_n = 1'b0;
        interval_tick = 1'b0;
        mon_clk = 2'b00;
        cfg_size = ACC_W'(sz); cfg_declare = ACC_W'(dcl);
        cfg_clear = ACC_W'(clr); cfg_decay = 2'(dec); fast_sel = fs;
        for (int i = 0; i < 2; i++) begin
            m_acc[i] = 0; m_lk[i] = 0; m_alm[i] = 0; prev_dead[i] = 0;
            ph[i] = 0; stall[i] = 0; pend[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        check(act_alarm == 2'b00 && in_valid == 2'b11, "R10", {act_alarm, in_valid}, 3);
        rst_n = 1'b1;
    endtask

    task automatic expect_alarm(input int i, input bit v, input string req);
        check(act_alarm[i] == v && in_valid[i] == !v, req, act_alarm[i], v);
    endtask

    initial begin
        // Scenario A: declare, saturation, hysteresis release, independence
        do_reset(10, 8, 1, 0, 2'b00);
        cur_req = "R5";
        for (int n = 0; n < 7; n++) run_interval(2, 0);
        expect_alarm(0, 0, "R5");
        run_interval(2, 0);
        expect_alarm(0, 1, "R5");
        expect_alarm(1, 0, "R9");
        cur_req = "R7";
        for (int n = 0; n < 7; n++) run_interval(2, 0);
        cur_req = "R6";
        for (int n = 0; n < 8; n++) run_interval(0, 0);
        expect_alarm(0, 1, "R6");
        expect_alarm(0, 1, "R7");
        run_interval(0, 0);
        expect_alarm(0, 0, "R6");

        // Scenario B: per-type gap limit
        do_reset(10, 8, 1, 0, 2'b01);
        cur_req = "R2";
        for (int n = 0; n < 8; n++) run_interval(1, 1);
        expect_alarm(1, 1, "R2");
        expect_alarm(0, 0, "R2");
        cur_req = "R1";
        run_interval(2, 0);
        expect_alarm(1, 1, "R1");

        // Scenario C: fill restarts leak period (decay 2)
        do_reset(6, 4, 2, 2, 2'b00);
        cur_req = "R4";
        for (int n = 0; n < 3; n++) run_interval(2, 0);
        for (int n = 0; n < 6; n++) run_interval(0, 0);
        run_interval(2, 0);
        run_interval(0, 0);
        expect_alarm(0, 0, "R4");
        run_interval(2, 0);
        expect_alarm(0, 1, "R4");

        // Scenario D: no underflow
        do_reset(5, 3, 1, 0, 2'b00);
        cur_req = "R8";
        for (int n = 0; n < 5; n++) run_interval(0, 0);
        run_interval(2, 2);
        run_interval(2, 2);
        expect_alarm(0, 0, "R8");
        run_interval(2, 2);
        expect_alarm(0, 1, "R8");
        expect_alarm(1, 1, "R9");

        // Scenario E: stopped clock spans a strobe
        do_reset(5, 3, 1, 0, 2'b00);
        cur_req = "R11";
        run_interval(3, 0);
        run_interval(3, 0);
        expect_alarm(0, 0, "R11");
        run_interval(0, 0);
        expect_alarm(0, 1, "R11");

        // Scenario F: leak once per two clean intervals (decay 1)
        do_reset(4, 2, 0, 1, 2'b00);
        cur_req = "R3";
        run_interval(0, 2);
        run_interval(0, 0);
        run_interval(0, 0);
        run_interval(0, 2);
        expect_alarm(1, 0, "R3");
        run_interval(0, 0);
        run_interval(0, 2);
        expect_alarm(1, 1, "R3");

        // Scenario G: decay 3 keeps level over seven clean intervals
        do_reset(4, 2, 0, 3, 2'b00);
        cur_req = "R3";
        run_interval(2, 0);
        for (int n = 0; n < 7; n++) run_interval(0, 0);
        run_interval(2, 0);
        expect_alarm(0, 1, "R3");

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule